// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block is the serial edge of one voice channel on a time-division-multiplexed backplane. It runs on the channel's bit clock, counts bit periods from an 8 kHz frame pulse, and opens two windows per frame: an input slot where a word is shifted in from the serial data line, and an output slot where a word is shifted out. Each captured word goes to a processing core as a one-period valid pulse. The core's result is taken at the start of the output slot.

Slot width follows the coding direction. When encoding, the wide 8-bit sample arrives and a 4-bit code leaves. When decoding, a 4-bit code arrives and an 8-bit sample leaves. A bypass setting skips the core and sends the last captured word straight back out, using 8-bit slots when encoding and 4-bit slots when decoding. An idle setting keeps the output driver off and stops capture. The frame length in bit periods is a parameter. A slot whose bits would fall past the end of the frame never opens.

Top module: `tsa_channel`

## Requirements
- R1: A frame pulse sampled high on a falling edge of `dclk` makes the next rising edge the start of bit 0. Bit periods are then counted up to `FRAME_BITS`-1, and slot n of width W covers bits n*W to n*W+W-1. After the last bit no slot is active until the next frame pulse.
- R2: Input data is sampled on falling edges of `dclk` inside the input slot, most significant bit first.
- R3: With `cfg_compress`=1 the input slot is 8 bits and the output slot 4 bits. With `cfg_compress`=0 the input slot is 4 bits and the output slot 8 bits.
- R4: In the bit period right after the last input-slot bit, `cap_valid` is high for exactly one period. In that period `cap_word` holds the word. A 4-bit word sits in bits 3:0 and bits 7:4 are zero.
- R5: On the rising edge that opens the output slot, the block latches `core_word`. A 4-bit slot uses bits 3:0. The latched word is then driven on `dout` one bit per period, most significant first, with each bit changing on a rising edge.
- R6: `dout_oe` is high exactly during the bits of the output slot and low in every other bit period, including the period after the least significant bit.
- R7: A slot number whose first bit would be at or beyond `FRAME_BITS` never matches. It produces no capture and no output enable.
- R8: With `cfg_bypass`=1 and `cfg_idle`=0, both slots are 8 bits when encoding and 4 bits when decoding. The output word is the value `cap_word` held at the rising edge that opens the output slot. `cap_valid` stays low, while `cap_word` still updates.
- R9: With `cfg_idle`=1, `dout_oe` stays low, `cap_valid` stays low and `cap_word` does not change.
- R10: An active-low asynchronous reset clears `cap_valid`, `dout_oe` and `cap_word`, and parks the bit counter so that no slot is active until a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Channel bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame pulse, one bit period wide |
| din | input | 1 | Serial input data |
| cfg_compress | input | 1 | 1 = encode (8-bit in, 4-bit out), 0 = decode |
| cfg_bypass | input | 1 | Pass captured words straight to the output slot |
| cfg_idle | input | 1 | Disable output driver and capture |
| cfg_in_slot | input | 6 | Input slot number |
| cfg_out_slot | input | 6 | Output slot number |
| core_word | input | 8 | Processed word from the core |
| cap_valid | output | 1 | One-period strobe for a captured word |
| cap_word | output | 8 | Last captured word, right-justified |
| dout | output | 1 | Serial output data |
| dout_oe | output | 1 | Output driver enable (low = high impedance) |

## Verification
The assertions assume a frame pulse at most one bit period wide. They also assume the configuration inputs change only in a bit period where no slot is open, so the slot width cannot change partway through a slot. The stimulus keeps to this by writing new settings only in the frame-pulse period, while the counter is parked past the frame end. Each frame uses fresh random serial data and random slot numbers. Directed frames add the cases that need particular timing: a slot ending on the last bit of the frame, an output slot that opens on the same edge as a capture, an output slot placed before the input slot, and slot numbers past the frame end.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned SLOT_W = 6;

  // log2 of slot width: wide slots carry 8 bits, narrow slots 4
  function automatic int unsigned width_log2(input logic wide);
    return wide ? 32'd3 : 32'd2;
  endfunction

  // does bit period idx fall inside slot 'slot' of the given width
  function automatic logic slot_hit(input int unsigned idx, input int unsigned frame_bits,
                                    input logic wide, input logic [SLOT_W-1:0] slot);
    return (idx < frame_bits) && ((idx >> width_log2(wide)) == 32'(slot));
  endfunction

  // bit position inside the slot, 0 = first (MSB)
  function automatic logic [2:0] bit_pos(input int unsigned idx, input logic wide);
    return 3'(idx & (wide ? 32'd7 : 32'd3));
  endfunction

  function automatic logic [2:0] last_pos(input logic wide);
    return wide ? 3'd7 : 3'd3;
  endfunction
endpackage

// File: rtl/tsa_frame_ctr.sv
module tsa_frame_ctr #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             dclk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] bit_idx,
  output logic [CNT_W-1:0] nxt_idx
);
  localparam logic [CNT_W-1:0] PARK = CNT_W'(FRAME_BITS);

  logic fs_q;

  // frame pulse is set up to the falling edge
  always_ff @(negedge dclk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync;
  end

  always_comb begin
    if (fs_q)                nxt_idx = '0;
    else if (bit_idx >= PARK) nxt_idx = PARK;
    else                     nxt_idx = bit_idx + 1'b1;
  end

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) bit_idx <= PARK;
    else        bit_idx <= nxt_idx;
  end

  a_r1_frame_start: assert property (@(posedge dclk) disable iff (!rst_n)
    fs_q |=> bit_idx == '0);
  a_r1_count_step: assert property (@(posedge dclk) disable iff (!rst_n)
    (!fs_q && bit_idx < PARK) |=> bit_idx == CNT_W'($past(bit_idx) + 1'b1));
  a_r10_parked: assert property (@(posedge dclk) disable iff (!rst_n)
    (!fs_q && bit_idx == PARK) |=> bit_idx == PARK);
endmodule

// File: rtl/tsa_rx.sv
module tsa_rx
  import tsa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              dclk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              in_wide,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic              capture_en,
  input  logic              to_core,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_word
);
  logic [WORD_W-1:0] shreg;
  logic              in_hit;
  logic              cap_evt;

  assign in_hit  = slot_hit(32'(bit_idx), FRAME_BITS, in_wide, in_slot);
  assign cap_evt = capture_en && in_hit && (bit_pos(32'(bit_idx), in_wide) == last_pos(in_wide));

  // serial data sampled on the falling edge, MSB first
  always_ff @(negedge dclk or negedge rst_n) begin
    if (!rst_n)      shreg <= '0;
    else if (in_hit) shreg <= {shreg[WORD_W-2:0], din};
  end

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_word  <= '0;
    end else begin
      cap_valid <= cap_evt && to_core;
      if (cap_evt) cap_word <= in_wide ? shreg : {4'h0, shreg[3:0]};
    end
  end

  a_r4_single_pulse: assert property (@(posedge dclk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);
  a_r9_no_capture_idle: assert property (@(posedge dclk) disable iff (!rst_n)
    cap_valid |-> $past(capture_en));
  a_r4_narrow_upper_zero: assert property (@(posedge dclk) disable iff (!rst_n)
    (cap_valid && !$past(in_wide)) |-> cap_word[7:4] == 4'h0);
endmodule

// File: rtl/tsa_tx.sv
module tsa_tx
  import tsa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              dclk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [CNT_W-1:0]  nxt_idx,
  input  logic              out_wide,
  input  logic [SLOT_W-1:0] out_slot,
  input  logic              out_en,
  input  logic [WORD_W-1:0] src_word,
  output logic              dout,
  output logic              dout_oe
);
  logic [WORD_W-1:0] out_word;
  logic              out_hit;
  logic              slot_open;
  logic [2:0]        pos;
  logic              at_lsb;

  assign slot_open = slot_hit(32'(nxt_idx), FRAME_BITS, out_wide, out_slot)
                   && (bit_pos(32'(nxt_idx), out_wide) == 3'd0);
  assign out_hit   = slot_hit(32'(bit_idx), FRAME_BITS, out_wide, out_slot);
  assign pos       = bit_pos(32'(bit_idx), out_wide);
  assign at_lsb    = out_hit && (pos == last_pos(out_wide));

  // next word taken on the rising edge that opens the slot
  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n)         out_word <= '0;
    else if (slot_open) out_word <= src_word;
  end

  assign dout_oe = out_en && out_hit;
  assign dout    = dout_oe ? out_word[last_pos(out_wide) - pos] : 1'b0;

  a_r5_word_hold: assert property (@(posedge dclk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(out_word));
  a_r6_drop_after_lsb: assert property (@(posedge dclk) disable iff (!rst_n)
    (dout_oe && at_lsb) |=> !dout_oe);
  a_r5_latch_opens: assert property (@(posedge dclk) disable iff (!rst_n)
    (slot_open && out_en) |=> dout_oe);
endmodule

// File: rtl/tsa_channel.sv
module tsa_channel
  import tsa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic        dclk,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic        din,
  input  logic        cfg_compress,
  input  logic        cfg_bypass,
  input  logic        cfg_idle,
  input  logic [5:0]  cfg_in_slot,
  input  logic [5:0]  cfg_out_slot,
  input  logic [7:0]  core_word,
  output logic        cap_valid,
  output logic [7:0]  cap_word,
  output logic        dout,
  output logic        dout_oe
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  nxt_idx;
  logic              bypass_on;
  logic              in_wide;
  logic              out_wide;
  logic [WORD_W-1:0] src_word;

  // bypass keeps one width on both sides; otherwise the sides differ
  assign bypass_on = cfg_bypass && !cfg_idle;
  assign in_wide   = cfg_compress;
  assign out_wide  = bypass_on ? cfg_compress : !cfg_compress;
  assign src_word  = bypass_on ? cap_word : core_word;

  tsa_frame_ctr #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctr (
    .dclk(dclk), .rst_n(rst_n), .fsync(fsync),
    .bit_idx(bit_idx), .nxt_idx(nxt_idx)
  );

  tsa_rx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
    .dclk(dclk), .rst_n(rst_n), .din(din), .bit_idx(bit_idx),
    .in_wide(in_wide), .in_slot(cfg_in_slot),
    .capture_en(!cfg_idle), .to_core(!bypass_on),
    .cap_valid(cap_valid), .cap_word(cap_word)
  );

  tsa_tx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_tx (
    .dclk(dclk), .rst_n(rst_n), .bit_idx(bit_idx), .nxt_idx(nxt_idx),
    .out_wide(out_wide), .out_slot(cfg_out_slot), .out_en(!cfg_idle),
    .src_word(src_word), .dout(dout), .dout_oe(dout_oe)
  );

  a_r9_idle_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
    ($past(cfg_idle) && cfg_idle) |-> (!dout_oe && !cap_valid));
  a_r8_bypass_no_strobe: assert property (@(posedge dclk) disable iff (!rst_n)
    $past(bypass_on) |-> !cap_valid);
endmodule

// File: tb/test_tsa_channel.sv
module test_tsa_channel;
  localparam int CLK_PERIOD = 20;
  localparam int FB = 256;

  logic       dclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       din = 1'b0;
  logic       cfg_compress = 1'b0, cfg_bypass = 1'b0, cfg_idle = 1'b0;
  logic [5:0] cfg_in_slot = '0, cfg_out_slot = '0;
  logic [7:0] core_word = '0;
  logic       cap_valid, dout, dout_oe;
  logic [7:0] cap_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int   idx = FB, prev_idx = FB;
  bit   prev_fs = 0;
  logic [7:0] m_sh = '0, m_cap = '0, m_core = '0, m_out = '0;
  logic n_comp, n_byp, n_idle;
  logic [5:0] n_in, n_out;

  tsa_channel #(.FRAME_BITS(FB)) i_tsa_channel (
    .dclk(dclk), .rst_n(rst_n), .fsync(fsync), .din(din),
    .cfg_compress(cfg_compress), .cfg_bypass(cfg_bypass), .cfg_idle(cfg_idle),
    .cfg_in_slot(cfg_in_slot), .cfg_out_slot(cfg_out_slot), .core_word(core_word),
    .cap_valid(cap_valid), .cap_word(cap_word), .dout(dout), .dout_oe(dout_oe)
  );

  always #(CLK_PERIOD/2) dclk = ~dclk;

  function automatic int wbits(input logic wide);
    return wide ? 8 : 4;
  endfunction
  function automatic bit b_hit(input int i, input logic wide, input logic [5:0] s);
    int w = wbits(wide);
    return (i < FB) && (i >= int'(s) * w) && (i < int'(s) * w + w);
  endfunction
  function automatic int b_pos(input int i, input logic wide);
    return i % wbits(wide);
  endfunction
  function automatic logic [7:0] xform(input logic [7:0] w);
    return {w[2:0], w[7:3]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at bit %0d", req, what, act, exp, idx);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one bit period: model update, checks, then drive the next stimulus
  task automatic step(input logic fs, input logic d, input bit load);
    logic [7:0] old_cap;
    bit evt, byp, exp_oe;
    logic ow;
    @(posedge dclk); #(CLK_PERIOD/4);
    prev_idx = idx;
    idx = prev_fs ? 0 : (idx >= FB ? FB : idx + 1);          // R1
    old_cap = m_cap;
    evt = 0;
    if (!cfg_idle && b_hit(prev_idx, cfg_compress, cfg_in_slot)
        && b_pos(prev_idx, cfg_compress) == wbits(cfg_compress) - 1) begin
      evt = 1;
      m_cap = cfg_compress ? m_sh : (m_sh & 8'h0F);          // R2 R3
    end
    byp = cfg_bypass && !cfg_idle;
    ow  = byp ? cfg_compress : !cfg_compress;
    if (b_hit(idx, ow, cfg_out_slot) && b_pos(idx, ow) == 0)
      m_out = byp ? old_cap : m_core;
    chk(byp ? "R8" : (cfg_idle ? "R9" : "R4"), "cap_valid", int'(cap_valid), int'(evt && !byp));
    if (evt) chk(byp ? "R8" : "R4", "cap_word", int'(cap_word), int'(m_cap));
    if (cfg_idle) chk("R9", "cap_word_held", int'(cap_word), int'(m_cap));
    exp_oe = !cfg_idle && b_hit(idx, ow, cfg_out_slot);
    chk(cfg_idle ? "R9" : "R6", "dout_oe", int'(dout_oe), int'(exp_oe));
    if (exp_oe) chk(byp ? "R8" : "R5", "dout", int'(dout), int'(m_out[wbits(ow) - 1 - b_pos(idx, ow)]));
    if (evt && !byp) begin
      m_core = xform(m_cap);
      core_word = m_core;
    end
    if (load) begin
      cfg_compress = n_comp; cfg_bypass = n_byp; cfg_idle = n_idle;
      cfg_in_slot = n_in; cfg_out_slot = n_out;
    end
    fsync = fs; din = d; prev_fs = fs;
    if (b_hit(idx, cfg_compress, cfg_in_slot)) m_sh = {m_sh[6:0], d};
  endtask

  task automatic frame(input logic comp, input logic byp, input logic idl,
                       input logic [5:0] si, input logic [5:0] so);
    n_comp = comp; n_byp = byp; n_idle = idl; n_in = si; n_out = so;
    step(1'b1, 1'b0, 1);
    for (int k = 0; k < FB; k++) step(1'b0, 1'($urandom), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge dclk);
    #(CLK_PERIOD/4);
    // R10: reset state
    chk("R10", "cap_valid", int'(cap_valid), 0);
    chk("R10", "dout_oe", int'(dout_oe), 0);
    chk("R10", "cap_word", int'(cap_word), 0);
    rst_n = 1'b1;
    // R10 R1: no slot active before the first frame pulse
    repeat (4) step(1'b0, 1'b1, 0);
    // R3 R5: encode, 8-bit in at slot 0, 4-bit out at the last slot
    frame(1, 0, 0, 6'd0, 6'd63);
    frame(1, 0, 0, 6'd1, 6'd0);
    // R3 R4: decode, 4-bit input slot ending on the last frame bit
    frame(0, 0, 0, 6'd63, 6'd5);
    frame(0, 0, 0, 6'd10, 6'd31);
    // R7: 8-bit slots past the frame end never match
    frame(1, 0, 0, 6'd40, 6'd9);
    frame(0, 0, 0, 6'd2, 6'd33);
    // R8: bypass, output opens on the capture edge, then out before in
    frame(1, 1, 0, 6'd2, 6'd3);
    frame(0, 1, 0, 6'd7, 6'd2);
    frame(0, 1, 0, 6'd7, 6'd2);
    // R9: idle, also with bypass requested
    frame(1, 0, 1, 6'd4, 6'd4);
    frame(0, 1, 1, 6'd1, 6'd20);
    frame(1, 0, 0, 6'd5, 6'd12);
    for (int f = 0; f < 40; f++)
      frame(1'($urandom), 1'(($urandom % 4) == 0), 1'(($urandom % 6) == 0),
            6'($urandom), 6'($urandom));
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    done = 1;
    summary();
  end
endmodule